// File: doc/BRIEF.md
# External Bus Handover Arbiter

This block decides when a processor core gives up its external memory bus to another master, and when it takes the bus back. The other master raises a request line that is not tied to the core clock. The block passes it through a synchronizer, then grants the bus as soon as the core is not in the middle of an external access. While the bus is granted, the core's address, data and strobe drivers are placed in high impedance.

The core reports two things each cycle: whether an external access is in progress, and whether its next instruction needs the external bus. In the normal mode the core stops for the whole time the bus is granted. In run-on mode it keeps running until it reaches an instruction that needs the bus. A hung flag shows that the core is ready for an external access but is blocked by the grant. The grant can be issued in the idle cycle between two external accesses of one instruction. Arbitration keeps working while the block reset is held, so another master can take the bus during reset and boot.

Top module: `bus_handover_arb`

## Requirements
- R1: While `rst` is high and `bus_req_i` is low, all four outputs settle low within three clock edges.
- R2: `bus_req_i` passes through two synchronizer flops. With no external access in progress, `grant_o` rises on the third rising edge after the request is set, so it follows the synchronized request by one cycle.
- R3: No grant is issued in any cycle that follows a cycle with `ext_busy_i` high. The grant rises in the cycle after the last busy cycle.
- R4: A single idle cycle between two accesses is enough to grant. Once granted, a later `ext_busy_i` does not withdraw the grant.
- R5: `drv_hiz_o` is high exactly when `grant_o` is high.
- R6: With `go_mode_i` low, `core_halt_o` equals `grant_o`. With it high, the core halts only when it is granted and `ext_need_i` is high, and the halt appears one cycle after the need is seen.
- R7: `grant_hung_o` is high one cycle after `ext_need_i` is seen high while the bus is granted, in either mode. It is never high without a halt.
- R8: On the first edge after the synchronized request is seen low, `grant_o`, `grant_hung_o`, `core_halt_o` and `drv_hiz_o` all fall together.
- R9: While the synchronized request stays high, the grant is held.
- R10: While `rst` is high, the grant follows the request and `ext_busy_i` and `ext_need_i` are ignored. With go mode off, `core_halt_o` still follows the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; masks the core status inputs |
| bus_req_i | input | 1 | Asynchronous bus request from the external master |
| ext_busy_i | input | 1 | Core has an external access in progress this cycle |
| ext_need_i | input | 1 | Core's next instruction needs the external bus |
| go_mode_i | input | 1 | Keep the core running while the bus is granted |
| grant_o | output | 1 | Bus grant to the external master |
| grant_hung_o | output | 1 | Core is blocked on an external access by the grant |
| drv_hiz_o | output | 1 | High-impedance enable for address, data and strobe drivers |
| core_halt_o | output | 1 | Stall the core |

## Verification
The bench counts the synchronizer latency edge by edge. A design with one stage too few or too many grants a cycle early or late. It holds a request across a long external access and then opens a one-cycle gap with the access resuming. A design that ignores the busy input would grant mid-access, and one that re-checks busy after granting would drop the bus. Run-on mode is checked with the need input low and then high: a design that ties halt to the grant stops the core too early, and one that mistimes the hung flag misses the stall. Release is checked for all four outputs falling on one edge. A final pass with reset held and the status inputs deliberately active shows that arbitration does not wait for reset to end.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic busy;   // external access in progress
    logic need;   // next instruction wants the bus
  } core_view_t;
endpackage

// File: rtl/bus_req_sync.sv
module bus_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain_q <= async_i;
    end else begin : g_multi
      always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl
  import bus_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_sync_i,
  input  core_view_t core_i,
  output logic       grant_next_o,
  output logic       grant_q_o,
  output logic       hiz_q_o
);
  logic grant_d;

  // Once granted only the request matters; before that, wait out any access.
  always_comb begin
    if (grant_q_o) grant_d = req_sync_i;
    else           grant_d = req_sync_i && !core_i.busy;
  end

  always_ff @(posedge clk) begin
    grant_q_o <= grant_d;
    hiz_q_o   <= grant_d;
  end

  assign grant_next_o = grant_d;

  // R3: a busy cycle blocks a new grant on the next edge
  a_r3_no_grant_mid_access: assert property (@(posedge clk) disable iff (rst)
    (!grant_q_o && core_i.busy) |=> !grant_q_o);
  // R9: grant held while the request stays up
  a_r9_hold_grant: assert property (@(posedge clk) disable iff (rst)
    (grant_q_o && req_sync_i) |=> grant_q_o);
  // R8: grant drops one edge after the request is seen low
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (grant_q_o && !req_sync_i) |=> !grant_q_o);
  // R5: driver high-impedance tracks the grant
  a_r5_hiz_tracks: assert property (@(posedge clk) disable iff (rst)
    hiz_q_o == grant_q_o);
endmodule

// File: rtl/bus_core_stall.sv
module bus_core_stall (
  input  logic clk,
  input  logic rst,
  input  logic grant_next_i,
  input  logic need_i,
  input  logic go_i,
  output logic halt_q_o,
  output logic hung_q_o
);
  always_ff @(posedge clk) begin
    halt_q_o <= grant_next_i && (!go_i || need_i);
    hung_q_o <= grant_next_i && need_i;
  end

  // R6: without run-on mode a grant always stops the core
  a_r6_stop_no_go: assert property (@(posedge clk) disable iff (rst)
    (!go_i && grant_next_i) |=> halt_q_o);
  // R6: in run-on mode the core keeps going until it needs the bus
  a_r6_run_on_go: assert property (@(posedge clk) disable iff (rst)
    (go_i && !need_i) |=> !halt_q_o);
  // R7: hung only ever appears together with a halt
  a_r7_hung_implies_halt: assert property (@(posedge clk) disable iff (rst)
    hung_q_o |-> halt_q_o);
endmodule

// File: rtl/bus_handover_arb.sv
module bus_handover_arb
  import bus_arb_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_req_i,
  input  logic ext_busy_i,
  input  logic ext_need_i,
  input  logic go_mode_i,
  output logic grant_o,
  output logic grant_hung_o,
  output logic drv_hiz_o,
  output logic core_halt_o
);
  logic       req_sync;
  logic       grant_next;
  core_view_t core_eff;

  // Core status is meaningless in reset; arbitration itself keeps running.
  assign core_eff.busy = ext_busy_i && !rst;
  assign core_eff.need = ext_need_i && !rst;

  bus_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .async_i(bus_req_i),
    .sync_o (req_sync)
  );

  bus_grant_ctrl u_grant (
    .clk         (clk),
    .rst         (rst),
    .req_sync_i  (req_sync),
    .core_i      (core_eff),
    .grant_next_o(grant_next),
    .grant_q_o   (grant_o),
    .hiz_q_o     (drv_hiz_o)
  );

  bus_core_stall u_stall (
    .clk         (clk),
    .rst         (rst),
    .grant_next_i(grant_next),
    .need_i      (core_eff.need),
    .go_i        (go_mode_i),
    .halt_q_o    (core_halt_o),
    .hung_q_o    (grant_hung_o)
  );

  // R8: status and halt never outlive the grant
  a_r8_fall_together: assert property (@(posedge clk) disable iff (rst)
    $fell(grant_o) |-> (!grant_hung_o && !core_halt_o && !drv_hiz_o));
endmodule

// File: tb/bus_handover_arb_bench.sv
module bus_handover_arb_bench;
  logic clk = 1'b0;
  logic rst, bus_req_i, ext_busy_i, ext_need_i, go_mode_i;
  logic grant_o, grant_hung_o, drv_hiz_o, core_halt_o;
  int   n_chk = 0;
  int   n_bad = 0;

  always #5 clk = ~clk;

  bus_handover_arb u_bus_handover_arb (
    .clk(clk), .rst(rst), .bus_req_i(bus_req_i), .ext_busy_i(ext_busy_i),
    .ext_need_i(ext_need_i), .go_mode_i(go_mode_i), .grant_o(grant_o),
    .grant_hung_o(grant_hung_o), .drv_hiz_o(drv_hiz_o), .core_halt_o(core_halt_o)
  );

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk4(input string req, input logic g, input logic h,
                      input logic z, input logic s);
    chk({req, " grant"}, grant_o, g);
    chk({req, " hung"},  grant_hung_o, h);
    chk({req, " hiz"},   drv_hiz_o, z);
    chk({req, " halt"},  core_halt_o, s);
  endtask

  task automatic drop_req();
    bus_req_i = 1'b0; ext_busy_i = 1'b0; ext_need_i = 1'b0;
    edges(4);
  endtask

  task automatic t_reset();
    rst = 1'b1; bus_req_i = 1'b0; ext_busy_i = 1'b0;
    ext_need_i = 1'b0; go_mode_i = 1'b0;
    edges(4);
    chk4("R1 reset idle", 0, 0, 0, 0);
    rst = 1'b0;
    edges(1);
    chk4("R1 after reset", 0, 0, 0, 0);
  endtask

  task automatic t_idle_grant();
    bus_req_i = 1'b1;
    edges(2);
    chk("R2 not yet granted after 2 edges", grant_o, 1'b0);
    edges(1);
    chk4("R2 R5 R6 granted after 3 edges", 1, 0, 1, 1);
    edges(5);
    chk("R9 grant held", grant_o, 1'b1);
    drop_req();
  endtask

  task automatic t_busy_wait();
    ext_busy_i = 1'b1; bus_req_i = 1'b1;
    edges(6);
    chk4("R3 no grant while busy", 0, 0, 0, 0);
    ext_busy_i = 1'b0;
    edges(1);
    chk4("R3 grant cycle after access", 1, 0, 1, 1);
    drop_req();
  endtask

  task automatic t_gap();
    ext_busy_i = 1'b1; bus_req_i = 1'b1;
    edges(4);
    chk("R3 first access blocks", grant_o, 1'b0);
    ext_busy_i = 1'b0;   // single idle cycle between accesses
    edges(1);
    chk("R4 grant in the gap", grant_o, 1'b1);
    ext_busy_i = 1'b1;
    edges(2);
    chk("R4 later busy keeps grant", grant_o, 1'b1);
    drop_req();
  endtask

  task automatic t_go_and_release();
    go_mode_i = 1'b1; bus_req_i = 1'b1;
    edges(3);
    chk4("R6 run-on granted, core running", 1, 0, 1, 0);
    ext_need_i = 1'b1;
    edges(1);
    chk4("R6 R7 core halts on need", 1, 1, 1, 1);
    bus_req_i = 1'b0;
    edges(2);
    chk4("R8 still granted before sync sees low", 1, 1, 1, 1);
    edges(1);
    chk4("R8 all fall together", 0, 0, 0, 0);
    ext_need_i = 1'b0; go_mode_i = 1'b0;
    edges(3);
  endtask

  task automatic t_hung_no_go();
    bus_req_i = 1'b1;
    edges(3);
    chk("R7 no hung without need", grant_hung_o, 1'b0);
    ext_need_i = 1'b1;
    edges(1);
    chk("R7 hung with need, normal mode", grant_hung_o, 1'b1);
    drop_req();
  endtask

  task automatic t_reset_arb();
    rst = 1'b1; ext_busy_i = 1'b1; ext_need_i = 1'b1; bus_req_i = 1'b1;
    edges(3);
    chk4("R10 grant in reset, busy and need ignored", 1, 0, 1, 1);
    bus_req_i = 1'b0;
    edges(3);
    chk4("R10 release in reset", 0, 0, 0, 0);
    ext_busy_i = 1'b0; ext_need_i = 1'b0;
    rst = 1'b0;
    edges(2);
  endtask

  initial begin
    t_reset();
    t_idle_grant();
    t_busy_wait();
    t_gap();
    t_go_and_release();
    t_hung_no_go();
    t_reset_arb();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule